// File: doc/BRIEF.md
# Pipelined ADC Power Sequencer and Sample Capture

This block sits between a chip's sample consumers and an external 12-bit pipelined converter with a parallel data bus. It owns the converter's two low-power control pins: a shutdown pin and an active-low output-enable pin. It turns a two-bit command into the pin pattern for one of four operating states. After power-up it issues the one-time shutdown pulse that the clock duty-cycle stabilizer needs.

While the sequencer is in the normal driven state, every clock the block registers the data bus and the over-range flag. It can optionally turn offset-binary data into signed two's complement. It presents the result as a valid-qualified stream. Valid is held low in every other state. After a wake-up, valid stays low for a recovery interval that depends on the state being left. It then stays low for a further flush of the converter's pipeline latency, so no stale or floating word is ever marked valid.

All intervals are counted in cycles of the block clock, which is the converter's sample clock. They are set by parameters.

Top module: `adc_link_ctrl`

## Requirements
- R1: Once the power-up pulse is over, `adc_shdn` equals bit 1 and `adc_oe_n` equals bit 0 of the command applied one clock earlier. The command codes are 00 run with outputs driven, 01 run with outputs tristated, 10 nap and 11 sleep.
- R2: After reset, both pins are held high for exactly `PULSE_CYC` clocks whatever the command is. The block then treats the end of the pulse as a departure from sleep.
- R3: `smp_valid` is high only when the pins were in the driven-run pattern (00) in the previous clock.
- R4: Leaving nap starts a recovery of `NAP_WAIT` clocks, counted only while the pins show a run pattern (00 or 01). Valid stays low throughout.
- R5: Leaving sleep starts a recovery of `SLEEP_WAIT` clocks under the same counting rule.
- R6: After the pins reach 00 with no recovery pending, `PIPE_LAT` further clocks pass before the first valid word. Any other pattern, or a pending recovery, resets this flush.
- R7: With `fmt_twos` = 1, `smp_data` is the bus word unchanged. With `fmt_twos` = 0, the bus is taken as offset binary and `smp_data` equals the bus value minus 2^(W-1) in two's complement. For example 0x800 becomes 0x000 and 0x000 becomes 0x800. The output is registered one clock after the bus.
- R8: `smp_ovr` is the over-range bit registered in the same clock as its data word, and it is forced low when that word is not valid.
- R9: A command change while a recovery is still pending restarts the recovery at full length. The length is the sleep length if any departure from sleep is still unfinished, and the nap length otherwise.
- R10: During reset both pins are high, and `smp_valid` and `smp_ovr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all logic on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 2 | Requested state: 00 run, 01 run tristated, 10 nap, 11 sleep |
| fmt_twos | input | 1 | 1: bus already two's complement; 0: bus is offset binary |
| adc_d | input | W | Converter data bus |
| adc_ovr | input | 1 | Converter over/under-range flag |
| adc_shdn | output | 1 | Converter shutdown pin |
| adc_oe_n | output | 1 | Converter output-enable pin, active low |
| smp_data | output | W | Signed sample |
| smp_ovr | output | 1 | Over-range flag for the word in `smp_data` |
| smp_valid | output | 1 | `smp_data` holds a trustworthy sample |

## Verification
The bench aims at the edges of every blanking window. These are the last pulse clock, the last recovery clock and the last flush clock. A design that is off by one at any of them would raise valid one clock early or late and show a mismatch on that clock.

It also leaves sleep and then changes command part-way through the recovery. A design that forgot the pending sleep departure would wake after the short nap interval.

The run-tristated state is exercised to catch valid leaking through while the bus floats. Bus values 0x000, 0x800 and 0xFFF are applied in both formats, which exposes a wrong bit flip or a sign error in the conversion.

// File: rtl/adcc_pkg.sv
package adcc_pkg;

  // bit 1 drives the shutdown pin, bit 0 the active-low output enable
  typedef enum logic [1:0] {
    M_RUN   = 2'b00,
    M_HIDE  = 2'b01,
    M_NAP   = 2'b10,
    M_SLEEP = 2'b11
  } adcc_mode_e;

  function automatic logic is_powered_down(input adcc_mode_e m);
    return m[1];
  endfunction

  function automatic logic shdn_of(input adcc_mode_e m);
    return m[1];
  endfunction

  function automatic logic oe_n_of(input adcc_mode_e m);
    return m[0];
  endfunction

endpackage

// File: rtl/adcc_mode_seq.sv
module adcc_mode_seq
  import adcc_pkg::*;
#(
  parameter int PULSE_CYC  = 200,
  parameter int NAP_WAIT   = 100,
  parameter int SLEEP_WAIT = 400000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  adcc_mode_e cmd,
  output adcc_mode_e cur,
  output logic       settled,
  output logic       pulse_done
);
  localparam int MAXW = (SLEEP_WAIT > NAP_WAIT) ? SLEEP_WAIT : NAP_WAIT;
  localparam int RW   = $clog2(MAXW + 1);
  localparam int PW   = $clog2(PULSE_CYC + 1);

  logic [PW-1:0] pulse_cnt;
  logic [RW-1:0] rec;
  logic          pend_sleep;

  logic mode_change;
  logic rec_busy;
  logic pend_next;

  // recovery length chosen on a command change
  function automatic logic [RW-1:0] wait_len(input adcc_mode_e left,
                                             input logic busy,
                                             input logic deep);
    if (is_powered_down(left) || busy)
      return deep ? RW'(SLEEP_WAIT) : RW'(NAP_WAIT);
    return '0;
  endfunction

  assign pulse_done  = (pulse_cnt == PW'(PULSE_CYC));
  assign mode_change = pulse_done && (cmd != cur);
  assign rec_busy    = (rec != '0);
  assign pend_next   = (cur == M_SLEEP) | (rec_busy & pend_sleep);
  assign settled     = pulse_done && (cur == M_RUN) && !rec_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_cnt  <= '0;
      cur        <= M_SLEEP;
      rec        <= '0;
      pend_sleep <= 1'b1;
    end else if (!pulse_done) begin
      pulse_cnt <= pulse_cnt + 1'b1;
    end else if (mode_change) begin
      cur        <= cmd;
      rec        <= wait_len(cur, rec_busy, pend_next);
      pend_sleep <= pend_next;
    end else if (rec_busy && !is_powered_down(cur)) begin
      rec <= rec - 1'b1;
    end
  end

  // R2
  pulse_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_done |-> (cur == M_SLEEP));

  // R4
  leave_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (NAP_WAIT > 0) && pulse_done && $past(pulse_done) &&
    $past(is_powered_down(cur)) && !is_powered_down(cur) |-> rec_busy);

  // R1
  pins_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pulse_done) && $past(cmd == cur) |-> $stable(cur));

endmodule

// File: rtl/adcc_flush.sv
module adcc_flush #(
  parameter int PIPE_LAT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic settled,
  output logic ready
);
  localparam int CW = $clog2(PIPE_LAT + 1);

  logic [CW-1:0] cnt;
  logic          full;

  assign full  = (cnt == CW'(PIPE_LAT));
  assign ready = settled && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!settled)
      cnt <= '0;
    else if (!full)
      cnt <= cnt + 1'b1;
  end

  // R6
  flush_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (PIPE_LAT > 0) && $rose(settled) |-> !ready);

endmodule

// File: rtl/adcc_capture.sv
module adcc_capture #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] adc_d,
  input  logic         adc_ovr,
  input  logic         fmt_twos,
  input  logic         ready,
  output logic [W-1:0] smp_data,
  output logic         smp_ovr,
  output logic         smp_valid
);
  // offset binary to two's complement is a flip of the top bit
  function automatic logic [W-1:0] to_signed(input logic [W-1:0] raw,
                                             input logic twos);
    return twos ? raw : {~raw[W-1], raw[W-2:0]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_data  <= '0;
      smp_ovr   <= 1'b0;
      smp_valid <= 1'b0;
    end else begin
      smp_data  <= to_signed(adc_d, fmt_twos);
      smp_ovr   <= adc_ovr & ready;
      smp_valid <= ready;
    end
  end

  // R8
  ovr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ovr |-> smp_valid);

endmodule

// File: rtl/adc_link_ctrl.sv
module adc_link_ctrl
  import adcc_pkg::*;
#(
  parameter int W          = 12,
  parameter int PULSE_CYC  = 200,
  parameter int NAP_WAIT   = 100,
  parameter int SLEEP_WAIT = 400000,
  parameter int PIPE_LAT   = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   cmd,
  input  logic         fmt_twos,
  input  logic [W-1:0] adc_d,
  input  logic         adc_ovr,
  output logic         adc_shdn,
  output logic         adc_oe_n,
  output logic [W-1:0] smp_data,
  output logic         smp_ovr,
  output logic         smp_valid
);
  adcc_mode_e cur;
  logic       settled;
  logic       pulse_done;
  logic       ready;

  adcc_mode_seq #(
    .PULSE_CYC (PULSE_CYC),
    .NAP_WAIT  (NAP_WAIT),
    .SLEEP_WAIT(SLEEP_WAIT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (adcc_mode_e'(cmd)),
    .cur       (cur),
    .settled   (settled),
    .pulse_done(pulse_done)
  );

  adcc_flush #(.PIPE_LAT(PIPE_LAT)) u_flush (
    .clk    (clk),
    .rst_n  (rst_n),
    .settled(settled),
    .ready  (ready)
  );

  adcc_capture #(.W(W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .adc_d    (adc_d),
    .adc_ovr  (adc_ovr),
    .fmt_twos (fmt_twos),
    .ready    (ready),
    .smp_data (smp_data),
    .smp_ovr  (smp_ovr),
    .smp_valid(smp_valid)
  );

  assign adc_shdn = shdn_of(cur);
  assign adc_oe_n = oe_n_of(cur);

  // R3
  valid_run_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(!adc_shdn && !adc_oe_n));

  // R2
  pulse_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_done |-> adc_shdn && adc_oe_n && !smp_valid);

endmodule

// File: tb/tb_adc_link_ctrl.sv
`timescale 1ns/1ps
module tb_adc_link_ctrl;
  localparam int W     = 12;
  localparam int PULSE = 8;
  localparam int NAPW  = 20;
  localparam int SLPW  = 60;
  localparam int LAT   = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   cmd = 2'b00;
  logic         fmt_twos = 1'b0;
  logic [W-1:0] adc_d = '0;
  logic         adc_ovr = 1'b0;
  logic         adc_shdn, adc_oe_n, smp_ovr, smp_valid;
  logic [W-1:0] smp_data;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  adc_link_ctrl #(
    .W(W), .PULSE_CYC(PULSE), .NAP_WAIT(NAPW), .SLEEP_WAIT(SLPW), .PIPE_LAT(LAT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .fmt_twos(fmt_twos),
    .adc_d(adc_d), .adc_ovr(adc_ovr), .adc_shdn(adc_shdn), .adc_oe_n(adc_oe_n),
    .smp_data(smp_data), .smp_ovr(smp_ovr), .smp_valid(smp_valid)
  );

  // behavioural reference model, integer state
  int m_pulse = 0, m_state = 3, m_wait = 0, m_flush = 0;
  bit m_deep = 1, m_valid = 0, m_ovr = 0;
  logic [W-1:0] m_data = '0;

  function automatic logic [W-1:0] expect_word(logic [W-1:0] raw, bit twos);
    int v;
    v = int'(raw);
    if (!twos) v = v - (1 << (W - 1));
    return W'(v);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pulse = 0; m_state = 3; m_wait = 0; m_deep = 1;
      m_flush = 0; m_valid = 0; m_ovr = 0; m_data = '0;
    end else begin
      bit good, ready_now, deep_new;
      good      = (m_state == 0) && (m_wait == 0) && (m_pulse >= PULSE);
      ready_now = good && (m_flush == LAT);
      m_valid   = ready_now;
      m_ovr     = adc_ovr && ready_now;
      m_data    = expect_word(adc_d, fmt_twos);
      if (good) begin
        if (m_flush < LAT) m_flush++;
      end else m_flush = 0;
      if (m_pulse < PULSE) m_pulse++;
      else if (int'(cmd) != m_state) begin
        deep_new = (m_state == 3) || (m_wait != 0 && m_deep);
        if (m_state >= 2 || m_wait != 0) m_wait = deep_new ? SLPW : NAPW;
        else m_wait = 0;
        m_deep  = deep_new;
        m_state = int'(cmd);
      end else if (m_wait != 0 && m_state < 2) m_wait--;
    end
  end

  task automatic compare(string tag);
    vectors++;
    if (adc_shdn !== m_state[1] || adc_oe_n !== m_state[0]) begin
      fails++;
      $display("FAIL %s pins: actual shdn=%0b oe_n=%0b expected shdn=%0b oe_n=%0b",
               tag, adc_shdn, adc_oe_n, m_state[1], m_state[0]);
    end
    if (smp_valid !== m_valid) begin
      fails++;
      $display("FAIL %s valid: actual %0b expected %0b at %0t", tag, smp_valid, m_valid, $time);
    end
    if (smp_ovr !== m_ovr) begin
      fails++;
      $display("FAIL R8 overflow: actual %0b expected %0b", smp_ovr, m_ovr);
    end
    if (m_valid && smp_data !== m_data) begin
      fails++;
      $display("FAIL R7 data: actual %h expected %h", smp_data, m_data);
    end
  endtask

  // one clock: compare on the falling edge, then drive new bus values
  task automatic step(int n, string tag, int pat = 0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare(tag);
      case (pat)
        1:       adc_d = (i % 3 == 0) ? 12'h000 : (i % 3 == 1) ? 12'h800 : 12'hFFF;
        default: adc_d = W'($urandom);
      endcase
      adc_ovr = $urandom_range(0, 1);
    end
  endtask

  initial begin
    // R10: reset state
    cmd = 2'b00;
    repeat (3) @(negedge clk);
    vectors++;
    if (adc_shdn !== 1'b1 || adc_oe_n !== 1'b1 || smp_valid !== 1'b0 || smp_ovr !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: actual %0b%0b%0b%0b expected 1100",
               adc_shdn, adc_oe_n, smp_valid, smp_ovr);
    end
    rst_n = 1'b1;
    // R2 pulse, then R5 sleep recovery, R6 flush, R7 offset binary
    step(PULSE + SLPW + LAT + 30, "R2/R5/R6");
    // R7 extremes in both formats
    step(12, "R7", 1);
    fmt_twos = 1'b1;
    step(12, "R7", 1);
    step(20, "R7");
    // R3 tristated run blanks valid, R1 pin pattern, R6 re-flush
    cmd = 2'b01;
    step(15, "R1/R3");
    cmd = 2'b00;
    step(LAT + 10, "R6");
    // R4 nap and its recovery
    fmt_twos = 1'b0;
    cmd = 2'b10;
    step(12, "R1/R3");
    cmd = 2'b00;
    step(NAPW + LAT + 10, "R4");
    // R9 sleep departure interrupted mid recovery by tristate, then back
    cmd = 2'b11;
    step(10, "R1");
    cmd = 2'b00;
    step(SLPW / 2, "R5");
    cmd = 2'b01;
    step(3, "R9");
    cmd = 2'b00;
    step(SLPW + LAT + 10, "R9");
    // R9 nap departure interrupted by sleep keeps long wait afterwards
    cmd = 2'b10;
    step(5, "R1");
    cmd = 2'b00;
    step(NAPW / 2, "R4");
    cmd = 2'b11;
    step(4, "R9");
    cmd = 2'b00;
    step(SLPW + LAT + 10, "R9");
    // R8 overflow alignment under continuous run
    step(40, "R8");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule